// File: doc/BRIEF.md
# Auxiliary-Channel Transaction Retry Sequencer

This block runs one whole auxiliary-channel transaction against a message-buffer style channel engine. When a request is accepted, it first makes sure the channel is idle, polling the engine's busy flag a bounded number of times with a fixed pause between polls. It then rejects requests that are too large. Otherwise it launches the transfer and waits, with a time limit, for the engine to finish. After every attempt it issues a write-back pulse that clears the engine's done and error flags.

Attempts follow a fixed retry policy. The block steps through a caller-supplied list of bit-clock divider values, and each divider gets a fixed number of attempts. A timeout error retries straight away, while a receive error waits a back-off interval first. A clean completion ends the loop. When the loop ends, the last captured status decides the outcome. The result is a signed code on a valid/ready output: a positive code is the validated reply length, and a negative code names the error. The reply bytes come with it.

All delays are cycle counts set by parameters. The defaults match 1 ms, 10 ms and 450 µs at a 200 MHz clock.

Top module: `aux_xact_seq`

## Requirements
- R1: Out of reset, req_ready is 1, res_valid is 0 and ch_start is 0. An accepted request drops req_ready until its result has been taken.
- R2: Before any transfer, ch_busy is sampled up to PROBES (3) times, with CYC_1MS cycles between samples. If every sample reads busy, the result is -1 (busy) and ch_start never pulses. If any sample reads idle, the transaction goes ahead.
- R3: Once the channel is idle, a req_send_len or req_recv_cap above MAXB (20) gives result -2 (too big), and no transfer is started.
- R4: Divider entries are used in list order, entry 0 in div_list bits [DIV_W-1:0]. A zero entry, or the end of the list, stops the walk. Each nonzero divider gets at most TRIES (5) attempts, and ch_div shows the divider in use during ch_start.
- R5: After a timeout error (ch_tmo_err), the next ch_start follows the clear pulse within 3 cycles. After a receive error (ch_rx_err), at least CYC_RXW cycles pass between the clear pulse and the next ch_start.
- R6: An attempt whose ch_busy stays high is abandoned after CYC_10MS cycles of waiting. Its status is captured anyway.
- R7: Every attempt is followed by exactly one ch_clear pulse.
- R8: When all attempts are spent, the last status decides the result, checked in this order: done clear gives -1, receive error gives -3 (I/O), timeout gives -4.
- R9: On a clean completion, a ch_rx_len of 0 or above MAXB gives -1. Otherwise the result is min(ch_rx_len, req_recv_cap). res_data carries the received bytes below that count, byte k in bits [8k+7:8k], and zero above it.
- R10: res_valid, res_code and res_data hold steady until res_ready is seen high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Sequencer idle, request taken when both high |
| req_data | input | 8*MAXB | Bytes to send, byte k at [8k+7:8k] |
| req_send_len | input | LW | Bytes to send |
| req_recv_cap | input | LW | Receive capacity of the caller |
| div_list | input | DIV_N*DIV_W | Candidate dividers, entry 0 in the low bits |
| ch_busy | input | 1 | Engine transfer in progress |
| ch_done | input | 1 | Engine completion flag |
| ch_tmo_err | input | 1 | Engine reply-timeout flag |
| ch_rx_err | input | 1 | Engine receive-error flag |
| ch_rx_len | input | LW | Engine received byte count |
| ch_rx_data | input | 8*MAXB | Engine received bytes |
| ch_start | output | 1 | One-cycle launch pulse |
| ch_clear | output | 1 | One-cycle flag write-back pulse |
| ch_div | output | DIV_W | Divider for the current attempt |
| ch_len | output | LW | Send length for the engine |
| ch_tx_data | output | 8*MAXB | Send bytes for the engine |
| res_valid | output | 1 | Result available |
| res_ready | input | 1 | Result accepted |
| res_code | output | 8 | Signed result: length, or -1 busy, -2 too big, -3 I/O, -4 timeout |
| res_data | output | 8*MAXB | Reply bytes, zero above the result length |

## Verification
The assertions assume the engine raises ch_busy in the cycle after ch_start, and that the engine's status flags and received length are stable once ch_busy falls. The bench responder follows that contract. It raises busy on the edge that sees the launch, drops it a few cycles later with the status chosen for that attempt, and holds a hung attempt busy until the clear pulse. Requests are presented only while req_ready is high, and res_ready is released only after the hold has been observed.

// File: rtl/aux_xact_seq.sv
module aux_xact_seq #(
  parameter int MAXB     = 20,
  parameter int DIV_N    = 3,
  parameter int DIV_W    = 8,
  parameter int TRIES    = 5,
  parameter int PROBES   = 3,
  parameter int CYC_1MS  = 200000,
  parameter int CYC_10MS = 2000000,
  parameter int CYC_RXW  = 90000,
  localparam int LW = $clog2(MAXB + 1) + 1,
  localparam int DW = 8 * MAXB
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_valid,
  output logic                   req_ready,
  input  logic [DW-1:0]          req_data,
  input  logic [LW-1:0]          req_send_len,
  input  logic [LW-1:0]          req_recv_cap,
  input  logic [DIV_N*DIV_W-1:0] div_list,
  input  logic                   ch_busy,
  input  logic                   ch_done,
  input  logic                   ch_tmo_err,
  input  logic                   ch_rx_err,
  input  logic [LW-1:0]          ch_rx_len,
  input  logic [DW-1:0]          ch_rx_data,
  output logic                   ch_start,
  output logic                   ch_clear,
  output logic [DIV_W-1:0]       ch_div,
  output logic [LW-1:0]          ch_len,
  output logic [DW-1:0]          ch_tx_data,
  output logic                   res_valid,
  input  logic                   res_ready,
  output logic signed [7:0]      res_code,
  output logic [DW-1:0]          res_data
);
  localparam int CW = $clog2(CYC_10MS + CYC_1MS + CYC_RXW + 1);
  localparam int IW = $clog2(DIV_N + 1);
  localparam int TW = $clog2(TRIES + PROBES + 1);
  localparam logic signed [7:0] E_BUSY  = -8'sd1;
  localparam logic signed [7:0] E_BIG   = -8'sd2;
  localparam logic signed [7:0] E_IO    = -8'sd3;
  localparam logic signed [7:0] E_TMO   = -8'sd4;

  typedef enum logic [3:0] {
    S_IDLE, S_PROBE, S_PWAIT, S_DIVSEL, S_START, S_WAIT,
    S_CLEAR, S_RXW, S_NEXT, S_FINAL, S_LEN, S_RES
  } st_t;

  st_t              st;
  logic [CW-1:0]    cnt;
  logic [TW-1:0]    tries;
  logic [IW-1:0]    idx;
  logic [LW-1:0]    s_len, cap, s_rlen, clamp;
  logic [DW-1:0]    tx, s_rdata, masked;
  logic             s_done, s_tmo, s_rx;
  logic [DIV_W-1:0] div_cur, div_pick;

  assign req_ready  = (st == S_IDLE);
  assign ch_start   = (st == S_START);
  assign ch_clear   = (st == S_CLEAR);
  assign res_valid  = (st == S_RES);
  assign ch_div     = div_cur;
  assign ch_len     = s_len;
  assign ch_tx_data = tx;
  assign clamp      = (s_rlen > cap) ? cap : s_rlen;

  always_comb begin
    div_pick = '0;
    for (int i = 0; i < DIV_N; i++)
      if (IW'(i) == idx) div_pick = div_list[i*DIV_W +: DIV_W];
  end

  for (genvar b = 0; b < MAXB; b++) begin : g_mask
    assign masked[8*b +: 8] = (LW'(b) < clamp) ? s_rdata[8*b +: 8] : 8'h00;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; cnt <= '0; tries <= '0; idx <= '0;
      s_len <= '0; cap <= '0; tx <= '0; div_cur <= '0;
      s_done <= 1'b0; s_tmo <= 1'b0; s_rx <= 1'b0;
      s_rlen <= '0; s_rdata <= '0; res_code <= '0; res_data <= '0;
    end else begin
      case (st)
        S_IDLE: if (req_valid) begin
          tx <= req_data; s_len <= req_send_len; cap <= req_recv_cap;
          s_done <= 1'b0; s_tmo <= 1'b0; s_rx <= 1'b0;
          tries <= '0; cnt <= '0; st <= S_PROBE;
        end
        S_PROBE:
          if (!ch_busy) begin
            if (s_len > LW'(MAXB) || cap > LW'(MAXB)) begin
              res_code <= E_BIG; res_data <= '0; st <= S_RES;
            end else begin
              idx <= '0; st <= S_DIVSEL;
            end
          end else if (tries == TW'(PROBES - 1)) begin
            res_code <= E_BUSY; res_data <= '0; st <= S_RES;
          end else begin
            tries <= tries + TW'(1); cnt <= '0; st <= S_PWAIT;
          end
        S_PWAIT:
          if (cnt == CW'(CYC_1MS - 1)) st <= S_PROBE;
          else cnt <= cnt + CW'(1);
        S_DIVSEL:
          if (div_pick == '0) st <= S_FINAL;
          else begin
            div_cur <= div_pick; tries <= '0; st <= S_START;
          end
        S_START: begin
          cnt <= '0; st <= S_WAIT;
        end
        S_WAIT:
          if (!ch_busy || cnt == CW'(CYC_10MS - 1)) begin
            s_done <= ch_done; s_tmo <= ch_tmo_err; s_rx <= ch_rx_err;
            s_rlen <= ch_rx_len; s_rdata <= ch_rx_data;
            st <= S_CLEAR;
          end else cnt <= cnt + CW'(1);
        S_CLEAR:
          if (s_tmo) st <= S_NEXT;
          else if (s_rx) begin
            cnt <= '0; st <= S_RXW;
          end else if (s_done) st <= S_LEN;
          else st <= S_NEXT;
        S_RXW:
          if (cnt == CW'(CYC_RXW - 1)) st <= S_NEXT;
          else cnt <= cnt + CW'(1);
        S_NEXT:
          if (tries == TW'(TRIES - 1)) begin
            idx <= idx + IW'(1); st <= S_DIVSEL;
          end else begin
            tries <= tries + TW'(1); st <= S_START;
          end
        S_FINAL: begin
          res_data <= '0;
          if (!s_done) begin res_code <= E_BUSY; st <= S_RES; end
          else if (s_rx) begin res_code <= E_IO; st <= S_RES; end
          else if (s_tmo) begin res_code <= E_TMO; st <= S_RES; end
          else st <= S_LEN;
        end
        S_LEN: begin
          if (s_rlen == '0 || s_rlen > LW'(MAXB)) begin
            res_code <= E_BUSY; res_data <= '0;
          end else begin
            res_code <= 8'(clamp); res_data <= masked;
          end
          st <= S_RES;
        end
        S_RES: if (res_ready) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/aux_xact_seq_chk.sv
module aux_xact_seq_chk #(
  parameter int DIV_N = 3,
  parameter int TRIES = 5,
  parameter int MAXB  = 20,
  parameter int DW    = 160
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              ch_start,
  input logic              ch_clear,
  input logic              res_valid,
  input logic              res_ready,
  input logic signed [7:0] res_code,
  input logic [DW-1:0]     res_data
);
  logic [15:0] starts;

  always_ff @(posedge clk) begin
    if (!rst_n) starts <= '0;
    else if (req_valid && req_ready) starts <= '0;
    else if (ch_start) starts <= starts + 16'd1;
  end

  assert_accept_R1: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> !req_ready);

  assert_budget_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ch_start |-> (int'(starts) < DIV_N * TRIES));

  assert_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> !ch_start && !ch_clear);

  assert_len_R9: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && res_code > 0 |-> int'(res_code) <= MAXB);

  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_ready |=> res_valid && $stable(res_code) && $stable(res_data));
endmodule

bind aux_xact_seq aux_xact_seq_chk #(
  .DIV_N(DIV_N), .TRIES(TRIES), .MAXB(MAXB), .DW(DW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .ch_start(ch_start), .ch_clear(ch_clear), .res_valid(res_valid),
  .res_ready(res_ready), .res_code(res_code), .res_data(res_data)
);

// File: tb/sim_aux_xact_seq.sv
`timescale 1ns/100ps
module sim_aux_xact_seq;
  localparam int MAXB = 20, DIV_N = 3, DIV_W = 8, TRIES = 5, PROBES = 3;
  localparam int C1 = 20, C10 = 200, CR = 8;
  localparam int LW = 6, DW = 160;
  localparam int K_OK = 0, K_TMO = 1, K_RX = 2, K_NODONE = 3, K_HANG = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_ready;
  logic [DW-1:0] req_data = '0;
  logic [LW-1:0] req_send_len = '0, req_recv_cap = '0;
  logic [DIV_N*DIV_W-1:0] div_list = {8'h33, 8'h22, 8'h11};
  logic ch_busy, ch_start, ch_clear;
  logic r_busy = 1'b0, r_done = 1'b0, r_tmo = 1'b0, r_rx = 1'b0, pre_busy = 1'b0;
  logic [LW-1:0] ch_rx_len = 6'd5, ch_len;
  logic [DW-1:0] ch_rx_data, ch_tx_data, res_data;
  logic [DIV_W-1:0] ch_div;
  logic res_valid, res_ready = 1'b1;
  logic signed [7:0] res_code;

  always #2.5 clk = ~clk;

  for (genvar b = 0; b < MAXB; b++) begin : g_rx
    assign ch_rx_data[8*b +: 8] = 8'hA0 + 8'(b);
  end
  assign ch_busy = r_busy | pre_busy;

  aux_xact_seq #(.MAXB(MAXB), .DIV_N(DIV_N), .DIV_W(DIV_W), .TRIES(TRIES),
    .PROBES(PROBES), .CYC_1MS(C1), .CYC_10MS(C10), .CYC_RXW(CR)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_data(req_data), .req_send_len(req_send_len), .req_recv_cap(req_recv_cap),
    .div_list(div_list), .ch_busy(ch_busy), .ch_done(r_done), .ch_tmo_err(r_tmo),
    .ch_rx_err(r_rx), .ch_rx_len(ch_rx_len), .ch_rx_data(ch_rx_data),
    .ch_start(ch_start), .ch_clear(ch_clear), .ch_div(ch_div), .ch_len(ch_len),
    .ch_tx_data(ch_tx_data), .res_valid(res_valid), .res_ready(res_ready),
    .res_code(res_code), .res_data(res_data));

  int checks = 0, fails = 0, cyc = 0;
  int script [0:15];
  int n_att = 0, r_kind = 0, r_cnt = 0;
  int div_log[$], gap_log[$];
  int clear_cnt = 0, last_clear = -1, last_start = 0, att_min = 1 << 30;
  int acc_cyc = 0, res_cyc = 0;
  int exp_q[$];
  logic [DW-1:0] expd_q[$];
  string cur_tag = "R1";

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // behavioural channel engine
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (ch_start) begin
      r_busy <= 1'b1; r_cnt <= 3;
      r_done <= 1'b0; r_tmo <= 1'b0; r_rx <= 1'b0;
      r_kind <= (n_att < 16) ? script[n_att] : script[15];
      n_att <= n_att + 1;
    end else if (r_busy) begin
      if (r_kind == K_HANG) begin
        if (ch_clear) r_busy <= 1'b0;
      end else if (r_cnt == 0) begin
        r_busy <= 1'b0;
        r_done <= (r_kind != K_NODONE);
        r_tmo  <= (r_kind == K_TMO);
        r_rx   <= (r_kind == K_RX);
      end else r_cnt <= r_cnt - 1;
    end
  end

  // logs and scoreboard monitor
  always @(negedge clk) begin
    if (ch_start) begin
      div_log.push_back(int'(ch_div));
      if (last_clear >= 0) gap_log.push_back(cyc - last_clear);
      last_start = cyc;
    end
    if (ch_clear) begin
      clear_cnt++;
      last_clear = cyc;
      if (cyc - last_start < att_min) att_min = cyc - last_start;
    end
    if (res_valid && res_ready) begin
      res_cyc = cyc;
      if (exp_q.size() == 0) chk(1'b0, {cur_tag, " unexpected result"}, res_code, 0);
      else begin
        int e;
        logic [DW-1:0] ed;
        e = exp_q.pop_front();
        ed = expd_q.pop_front();
        chk(int'(res_code) == e, {cur_tag, " code"}, res_code, e);
        chk(res_data == ed, {cur_tag, " data"}, res_data[63:0], ed[63:0]);
      end
    end
  end

  task automatic set_script(input int k0, input int n0, input int krest);
    for (int i = 0; i < 16; i++) script[i] = (i < n0) ? k0 : krest;
  endtask

  task automatic clear_logs();
    div_log.delete(); gap_log.delete();
    clear_cnt = 0; last_clear = -1; att_min = 1 << 30; n_att = 0;
  endtask

  task automatic run(input int slen, input int capv, input int exp_code, input int exp_n);
    logic [DW-1:0] ed;
    for (int i = 0; i < MAXB; i++) ed[8*i +: 8] = (i < exp_n) ? 8'hA0 + 8'(i) : 8'h00;
    exp_q.push_back(exp_code);
    expd_q.push_back(ed);
    @(negedge clk);
    clear_logs();
    req_send_len = LW'(slen); req_recv_cap = LW'(capv);
    req_data = {8{20'hC3A5F}};
    req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    acc_cyc = cyc;
    #1 req_valid = 1'b0;
    while (exp_q.size() != 0) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    set_script(K_OK, 16, K_OK);
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready == 1'b1, "R1 req_ready", req_ready, 1);
    chk(res_valid == 1'b0, "R1 res_valid", res_valid, 0);
    chk(ch_start == 1'b0, "R1 ch_start", ch_start, 0);

    // R9 basic success, R4 first divider used
    cur_tag = "R9"; ch_rx_len = 6'd5;
    run(4, 20, 5, 5);
    chk(div_log.size() == 1, "R4 one attempt", div_log.size(), 1);
    chk(div_log.size() > 0 && div_log[0] == 'h11, "R4 divider entry 0",
        div_log.size() > 0 ? div_log[0] : -1, 'h11);
    chk(clear_cnt == 1, "R7 one clear", clear_cnt, 1);

    // R2 channel stays busy
    cur_tag = "R2"; pre_busy = 1'b1;
    run(4, 20, -1, 0);
    chk(div_log.size() == 0, "R2 no start while busy", div_log.size(), 0);
    chk(res_cyc - acc_cyc >= 2 * C1, "R2 probe spacing", res_cyc - acc_cyc, 2 * C1);
    // R2 busy clears before last probe
    fork
      run(4, 20, 5, 5);
      begin repeat (30) @(negedge clk); pre_busy = 1'b0; end
    join
    chk(div_log.size() == 1, "R2 proceeds after idle", div_log.size(), 1);

    // R3 size limits
    cur_tag = "R3";
    run(21, 4, -2, 0);
    chk(div_log.size() == 0, "R3 no start send", div_log.size(), 0);
    run(4, 21, -2, 0);
    chk(div_log.size() == 0, "R3 no start recv", div_log.size(), 0);
    cur_tag = "R3 limit"; run(20, 20, 5, 5);

    // R5 timeouts then success on second divider
    cur_tag = "R5"; set_script(K_TMO, 5, K_OK);
    run(4, 20, 5, 5);
    chk(div_log.size() == 6, "R4 attempts", div_log.size(), 6);
    for (int i = 0; i < div_log.size(); i++)
      chk(div_log[i] == ((i < 5) ? 'h11 : 'h22), "R4 divider order", div_log[i], (i < 5) ? 'h11 : 'h22);
    for (int i = 0; i < gap_log.size(); i++)
      chk(gap_log[i] <= 3, "R5 timeout retry gap", gap_log[i], 3);

    // R5 receive error back-off
    set_script(K_RX, 1, K_OK);
    run(4, 20, 5, 5);
    chk(gap_log.size() == 1 && gap_log[0] >= CR, "R5 receive back-off",
        gap_log.size() > 0 ? gap_log[0] : -1, CR);

    // R8 all timeouts, zero divider stops list (R4)
    cur_tag = "R8"; div_list = {8'h00, 8'h22, 8'h11}; set_script(K_TMO, 16, K_TMO);
    run(4, 20, -4, 0);
    chk(div_log.size() == 10, "R4 zero entry stops", div_log.size(), 10);
    set_script(K_RX, 16, K_RX);
    run(4, 20, -3, 0);
    chk(div_log.size() == 10, "R8 io attempts", div_log.size(), 10);

    // R4 first divider zero
    cur_tag = "R4"; div_list = {8'h33, 8'h22, 8'h00};
    run(4, 20, -1, 0);
    chk(div_log.size() == 0, "R4 empty list", div_log.size(), 0);

    // R6 hung attempts, R8 missing done
    cur_tag = "R6"; div_list = {8'h33, 8'h22, 8'h11}; set_script(K_HANG, 16, K_HANG);
    run(4, 20, -1, 0);
    chk(clear_cnt == 15, "R7 clear per attempt", clear_cnt, 15);
    chk(att_min >= C10, "R6 wait limit", att_min, C10);
    cur_tag = "R8"; set_script(K_NODONE, 16, K_NODONE);
    run(4, 20, -1, 0);
    chk(div_log.size() == 15, "R8 nodone attempts", div_log.size(), 15);

    // R9 length validation and clamp
    cur_tag = "R9"; set_script(K_OK, 16, K_OK);
    ch_rx_len = 6'd0;  run(4, 20, -1, 0);
    ch_rx_len = 6'd25; run(4, 20, -1, 0);
    ch_rx_len = 6'd8;  run(4, 3, 3, 3);
    ch_rx_len = 6'd20; run(4, 20, 20, 20);

    // R10 hold under back-pressure
    cur_tag = "R10"; ch_rx_len = 6'd7; res_ready = 1'b0;
    fork
      run(4, 20, 7, 7);
      begin
        logic signed [7:0] c0;
        while (!res_valid) @(negedge clk);
        c0 = res_code;
        repeat (5) begin
          @(negedge clk);
          chk(res_valid == 1'b1 && res_code == c0, "R10 hold", res_code, c0);
        end
        res_ready = 1'b1;
      end
    join

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule